// File: doc/BRIEF.md
# Serial SAR converter control logic

This block is the digital controller of an 8-bit serial successive-approximation converter. A host frames each transaction by pulling an active-low select line low and sending a start bit on a serial input, followed by a channel number, most significant bit first. The controller latches the channel and spends one clock letting the analog multiplexer settle. It then runs one binary-search trial per clock, with the resistor ladder and comparator outside the block: it drives the trial code, and it takes back a single comparator bit that is high when the input lies above the trial level.

Each decision appears on the serial output as it is made, most significant bit first. The finished code is then replayed least significant bit first. A build-time parameter picks how the replay is paced. In one variant, a hold input freezes the output on the current bit, and every clock with the hold low moves the output to the next bit. In the other variant, the replay runs on its own every clock and the hold input is ignored. After the replay the output stays low until the select line is released.

The serial output is modelled as a data bit plus an output-enable. The enable low stands for high impedance, so a host may tie input and output together on one wire: the output is never driven while the address is being taken.

Top module: `sar_serial_ctrl`

## Requirements
- R1: At every clock edge where sel_n is high, the block clears: ser_oe, conv_busy, ser_out, trial_code and chan_sel are all 0 after that edge.
- R2: While sel_n is low and no frame has begun, ser_in zeros are ignored. The first 1 is the start bit. The next ADDR_W bits, most significant first, form the channel, and this channel appears on chan_sel after the edge that samples the last of those bits.
- R3: At that same edge, conv_busy and ser_oe go to 1, and trial_code becomes 8'h80. For exactly one clock (the settle clock), ser_out is 0.
- R4: Over the next 8 clocks, trial_code runs a binary search from the MSB down. At the end of each trial clock, the bit under test is kept if cmp_above is 1 and cleared if it is 0, and the next lower bit is set.
- R5: During each of the 8 trial clocks, ser_out follows cmp_above directly, so the result appears MSB first.
- R6: conv_busy falls at the edge that ends the eighth trial. From then on, trial_code holds the final result and ser_out shows result bit 0.
- R7: From the settle clock until sel_n returns high, ser_in has no effect. The result, chan_sel and the output stream are the same whatever ser_in does.
- R8: With HAS_HOLD=1, each edge with replay_hold=1 keeps ser_out unchanged. Each edge with replay_hold=0 moves ser_out to the next result bit in the order bit 1, bit 2 up to bit 7, and after bit 7 to 0.
- R9: With HAS_HOLD=0, the same bit 1 to bit 7 sequence advances on every edge after conversion, whatever replay_hold is.
- R10: After the replay, ser_out stays 0 with ser_oe at 1 and conv_busy at 0 until sel_n goes high. Start bits sent in this state do not begin a new frame.
- R11: A synchronous rst clears the block to the same state as R1, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low frame select; high clears the block |
| ser_in | input | 1 | Serial start bit and channel address |
| replay_hold | input | 1 | High holds the replayed bit, low advances it (HAS_HOLD=1 only) |
| cmp_above | input | 1 | Comparator: 1 when the analog input is above trial_code |
| ser_out | output | 1 | Serial result data |
| ser_oe | output | 1 | Drive enable for ser_out; 0 means high impedance |
| conv_busy | output | 1 | High from the settle clock to the end of the last trial |
| trial_code | output | RES_W | Trial level to the resistor ladder |
| chan_sel | output | ADDR_W | Latched channel to the analog multiplexer |

## Verification
The bench connects each DUT to a comparator model, so that every code from 00 to FF gives a known binary-search answer. The edge codes are included: all-zero input, an input of 1 (which must not leave bit 0 set) and the top of the scale. A design that lets ser_in into the address register after framing would change channel or result while ser_in toggles during the trials. A design that forgets the settle clock, or shows the MSB one clock late, fails the cycle-exact checks on ser_out. The same frames run on both replay variants with hold patterns of varying length: a replay that repeats bit 0, skips a bit or does not return to 0 gives a wrong bit at a known clock. Leading zeros before the start bit, a select release in the middle of a conversion, a reset in the middle of a frame, and start bits sent after the replay check that a frame begins only where it should.

// File: rtl/sar_serial_pkg.sv
package sar_serial_pkg;
  typedef enum logic [1:0] {
    PH_ADDR   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_CONV   = 2'd2,
    PH_OUT    = 2'd3
  } phase_e;
endpackage

// File: rtl/sar_addr_shift.sv
// Address capture: a marker bit travels up the register; when it lands in
// the top position the low bits are the channel number.
module sar_addr_shift #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              en,
  input  logic              ser_in,
  output logic              framed,
  output logic [ADDR_W-1:0] addr_nxt
);
  localparam int SH_W = ADDR_W + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_d;

  assign sh_d     = {sh_q[SH_W-2:0], ser_in};
  assign framed   = en & sh_d[SH_W-1];
  assign addr_nxt = sh_d[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (clr) begin
      sh_q <= '0;
    end else if (en) begin
      sh_q <= sh_d;
    end
  end
endmodule

// File: rtl/sar_engine.sv
// Successive-approximation register: one trial per step, MSB first.
module sar_engine #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic             step,
  input  logic             cmp_above,
  output logic [RES_W-1:0] trial,
  output logic             last
);
  localparam logic [RES_W-1:0] TOP = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] mask_q;

  assign last = mask_q[0];

  always_ff @(posedge clk) begin
    if (clr) begin
      trial  <= '0;
      mask_q <= '0;
    end else if (load) begin
      trial  <= TOP;
      mask_q <= TOP;
    end else if (step) begin
      trial  <= (cmp_above ? trial : (trial & ~mask_q)) | (mask_q >> 1);
      mask_q <= mask_q >> 1;
    end
  end
endmodule

// File: rtl/sar_readout.sv
// Serial output: zero during settle, live comparator during trials, then
// an LSB-first replay paced either by the hold input or by every clock.
module sar_readout #(
  parameter int RES_W    = 8,
  parameter bit HAS_HOLD = 1'b1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             framed,
  input  logic             step,
  input  logic             last,
  input  logic             in_conv,
  input  logic             in_out,
  input  logic             hold,
  input  logic             cmp_above,
  input  logic [RES_W-1:0] result,
  output logic             ser_out,
  output logic             ser_oe
);
  localparam int              CW    = $clog2(RES_W + 1);
  localparam logic [CW-1:0]   LIMIT = CW'(RES_W);

  logic [CW-1:0]    ptr_q;
  logic [CW-1:0]    ptr_nx;
  logic [RES_W-1:0] shr;
  logic             bit_q;
  logic             adv;

  assign adv     = HAS_HOLD ? ~hold : 1'b1;
  assign ptr_nx  = ptr_q + 1'b1;
  assign shr     = result >> ptr_nx;
  assign ser_out = in_conv ? cmp_above : bit_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      ser_oe <= 1'b0;
      bit_q  <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (framed) begin
        ser_oe <= 1'b1;
        bit_q  <= 1'b0;
      end
      if (step && last) begin
        bit_q <= cmp_above;
        ptr_q <= '0;
      end
      if (in_out && adv && (ptr_q < LIMIT)) begin
        ptr_q <= ptr_nx;
        bit_q <= shr[0];
      end
    end
  end
endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
  import sar_serial_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int RES_W    = 8,
  parameter bit HAS_HOLD = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              ser_in,
  input  logic              replay_hold,
  input  logic              cmp_above,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              conv_busy,
  output logic [RES_W-1:0]  trial_code,
  output logic [ADDR_W-1:0] chan_sel
);
  phase_e            phase_q;
  logic              clr;
  logic              framed;
  logic              last;
  logic              step;
  logic [ADDR_W-1:0] addr_nxt;

  assign clr       = rst | sel_n;
  assign step      = (phase_q == PH_CONV);
  assign conv_busy = (phase_q == PH_SETTLE) || (phase_q == PH_CONV);

  always_ff @(posedge clk) begin
    if (clr) begin
      phase_q  <= PH_ADDR;
      chan_sel <= '0;
    end else begin
      case (phase_q)
        PH_ADDR: if (framed) begin
          phase_q  <= PH_SETTLE;
          chan_sel <= addr_nxt;
        end
        PH_SETTLE: phase_q <= PH_CONV;
        PH_CONV:   if (last) phase_q <= PH_OUT;
        default:   phase_q <= PH_OUT;
      endcase
    end
  end

  sar_addr_shift #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .clr      (clr),
    .en       (phase_q == PH_ADDR),
    .ser_in   (ser_in),
    .framed   (framed),
    .addr_nxt (addr_nxt)
  );

  sar_engine #(.RES_W(RES_W)) u_eng (
    .clk       (clk),
    .clr       (clr),
    .load      (framed),
    .step      (step),
    .cmp_above (cmp_above),
    .trial     (trial_code),
    .last      (last)
  );

  sar_readout #(.RES_W(RES_W), .HAS_HOLD(HAS_HOLD)) u_out (
    .clk       (clk),
    .clr       (clr),
    .framed    (framed),
    .step      (step),
    .last      (last),
    .in_conv   (step),
    .in_out    (phase_q == PH_OUT),
    .hold      (replay_hold),
    .cmp_above (cmp_above),
    .result    (trial_code),
    .ser_out   (ser_out),
    .ser_oe    (ser_oe)
  );
endmodule

// File: rtl/sar_serial_chk.sv
module sar_serial_chk #(
  parameter int ADDR_W = 3,
  parameter int RES_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n,
  input logic              ser_out,
  input logic              ser_oe,
  input logic              conv_busy,
  input logic [RES_W-1:0]  trial_code,
  input logic [ADDR_W-1:0] chan_sel
);
  localparam logic [RES_W-1:0] TOP = {1'b1, {(RES_W-1){1'b0}}};

  p_deselect_clears_r1: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> (!ser_oe && !conv_busy && trial_code == '0 && chan_sel == '0));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !ser_oe |-> (!conv_busy && !ser_out && trial_code == '0));

  p_busy_drives_r3: assert property (@(posedge clk) disable iff (rst)
    conv_busy |-> ser_oe);

  p_settle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_busy) |-> (!ser_out && trial_code == TOP));

  p_done_keeps_drive_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(conv_busy) && !$past(sel_n) && !$past(rst)) |-> ser_oe);

  p_chan_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && conv_busy) |=> $stable(chan_sel));
endmodule

bind sar_serial_ctrl sar_serial_chk #(.ADDR_W(ADDR_W), .RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_n      (sel_n),
  .ser_out    (ser_out),
  .ser_oe     (ser_oe),
  .conv_busy  (conv_busy),
  .trial_code (trial_code),
  .chan_sel   (chan_sel)
);

// File: tb/tb_sar_serial_ctrl.sv
module tb_sar_serial_ctrl;
  localparam int AW = 3;
  localparam int RW = 8;
  // vector: {addr[14:12], analog level[11:4], clocks of hold before release[3:0]}
  localparam logic [14:0] VEC [6] = '{
    {3'd5, 8'hA5, 4'd2},
    {3'd0, 8'h00, 4'd0},
    {3'd7, 8'hFF, 4'd3},
    {3'd2, 8'h01, 4'd1},
    {3'd3, 8'h80, 4'd0},
    {3'd6, 8'h5A, 4'd4}
  };

  logic clk = 1'b0;
  logic rst, sel_n, ser_in, replay_hold;
  logic [RW-1:0] vin;
  logic cmp_h, cmp_a;
  logic out_h, oe_h, busy_h, out_a, oe_a, busy_a;
  logic [RW-1:0] trial_h, trial_a;
  logic [AW-1:0] chan_h, chan_a;
  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign cmp_h = (vin > trial_h);
  assign cmp_a = (vin > trial_a);

  sar_serial_ctrl #(.ADDR_W(AW), .RES_W(RW), .HAS_HOLD(1'b1)) dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ser_in(ser_in),
    .replay_hold(replay_hold), .cmp_above(cmp_h),
    .ser_out(out_h), .ser_oe(oe_h), .conv_busy(busy_h),
    .trial_code(trial_h), .chan_sel(chan_h));

  sar_serial_ctrl #(.ADDR_W(AW), .RES_W(RW), .HAS_HOLD(1'b0)) dut_auto (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ser_in(ser_in),
    .replay_hold(replay_hold), .cmp_above(cmp_a),
    .ser_out(out_a), .ser_oe(oe_a), .conv_busy(busy_a),
    .trial_code(trial_a), .chan_sel(chan_a));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic chk_clear(input string tag);
    chk({tag, " oe"},    32'(oe_h),    32'd0);
    chk({tag, " busy"},  32'(busy_h),  32'd0);
    chk({tag, " out"},   32'(out_h),   32'd0);
    chk({tag, " trial"}, 32'(trial_h), 32'd0);
    chk({tag, " chan"},  32'(chan_h),  32'd0);
    chk({tag, " auto oe"}, 32'(oe_a),  32'd0);
  endtask

  task automatic run_frame(input logic [AW-1:0] addr, input logic [RW-1:0] lvl, input int hold_n);
    int expv, hi, ptr_h, ptr_a, eh, ea;
    logic hv;
    vin = lvl;
    expv = (lvl == 0) ? 0 : int'(lvl) - 1;
    sel_n = 1'b0; ser_in = 1'b1; replay_hold = 1'b1;
    tick();
    for (int i = AW - 1; i >= 0; i--) begin
      ser_in = addr[i];
      tick();
    end
    chk("R2 chan_sel", 32'(chan_h), 32'(addr));
    chk("R2 auto chan_sel", 32'(chan_a), 32'(addr));
    chk("R3 busy at settle", 32'(busy_h), 32'd1);
    chk("R3 oe at settle", 32'(oe_h), 32'd1);
    chk("R3 zero at settle", 32'(out_h), 32'd0);
    chk("R3 trial at settle", 32'(trial_h), 32'h80);
    for (int j = 1; j <= RW; j++) begin
      int b;
      b = RW - j;
      ser_in = j[0];  // R7: toggling ser_in during conversion
      tick();
      hi = expv & ~((1 << (b + 1)) - 1);
      chk("R4 trial code", 32'(trial_h), 32'(hi | (1 << b)));
      chk("R5 live bit", 32'(out_h), 32'((expv >> b) & 1));
      chk("R5 auto live bit", 32'(out_a), 32'((expv >> b) & 1));
      chk("R3 busy in trial", 32'(busy_h), 32'd1);
      chk("R7 chan held", 32'(chan_h), 32'(addr));
    end
    tick();
    chk("R6 busy falls", 32'(busy_h), 32'd0);
    chk("R6 auto busy falls", 32'(busy_a), 32'd0);
    chk("R6 result", 32'(trial_h), 32'(expv));
    chk("R6 auto result", 32'(trial_a), 32'(expv));
    chk("R6 lsb shown", 32'(out_h), 32'(expv & 1));
    chk("R7 chan after", 32'(chan_h), 32'(addr));
    ptr_h = 0; ptr_a = 0;
    for (int m = 1; m <= 11; m++) begin
      hv = (m <= hold_n);
      replay_hold = hv;
      ser_in = 1'b1;  // R10: start bits after conversion must be ignored
      tick();
      if (!hv && ptr_h < RW) ptr_h++;
      if (ptr_a < RW) ptr_a++;
      eh = (ptr_h < RW) ? ((expv >> ptr_h) & 1) : 0;
      ea = (ptr_a < RW) ? ((expv >> ptr_a) & 1) : 0;
      chk("R8 hold replay", 32'(out_h), 32'(eh));
      chk("R9 auto replay", 32'(out_a), 32'(ea));
    end
    chk("R10 oe kept", 32'(oe_h), 32'd1);
    chk("R10 no new frame", 32'(busy_h), 32'd0);
    chk("R10 trailing low", 32'(out_a), 32'd0);
    sel_n = 1'b1; ser_in = 1'b0;
    tick();
    chk_clear("R1 deselect");
  endtask

  initial begin
    rst = 1'b1; sel_n = 1'b0; ser_in = 1'b1; replay_hold = 1'b0; vin = '0;
    tick(); tick(); tick();
    chk_clear("R11 reset");
    rst = 1'b0; sel_n = 1'b1;
    tick();
    chk_clear("R1 idle");

    for (int v = 0; v < 6; v++) begin
      run_frame(VEC[v][14:12], VEC[v][11:4], int'(VEC[v][3:0]));
    end

    // R2: leading zeros with select low do not start a frame
    sel_n = 1'b0; ser_in = 1'b0;
    for (int z = 0; z < 5; z++) begin
      tick();
      chk("R2 leading zero busy", 32'(busy_h), 32'd0);
      chk("R2 leading zero oe", 32'(oe_h), 32'd0);
    end
    run_frame(3'd4, 8'h3C, 0);

    // R1: select released in the middle of a conversion
    vin = 8'hC3; sel_n = 1'b0; ser_in = 1'b1;
    tick();
    for (int i = 0; i < AW; i++) begin ser_in = 1'b1; tick(); end
    tick(); tick(); tick();
    chk("R1 busy before abort", 32'(busy_h), 32'd1);
    sel_n = 1'b1;
    tick();
    chk_clear("R1 abort");
    run_frame(3'd1, 8'hC3, 1);

    // R11: reset in the middle of a frame
    sel_n = 1'b0; ser_in = 1'b1;
    tick();
    for (int i = 0; i < AW; i++) begin ser_in = 1'b0; tick(); end
    tick();
    rst = 1'b1;
    tick();
    chk_clear("R11 mid-frame reset");
    rst = 1'b0; sel_n = 1'b1;
    tick();
    run_frame(3'd0, 8'h10, 2);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule